// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns one IEEE-754 single-precision operand per accepted beat into a 32-bit two's-complement signed integer. It always chops toward zero and has no rounding-mode input. Alongside the integer it returns a three-bit exception vector, a write-enable copied from the operation's guard, and a destination tag. The three values leave together, so writeback can match them to the operation. A write-back stage or a register-file port consumes the output.

The unit is a three-stage pipeline. Stage one classifies the operand. Stage two aligns the mantissa and detects discarded fraction bits. Stage three applies the sign, saturates or zeroes the special cases, and masks the beat when the guard is false. Both edges of the block are valid/ready streams. A beat moves on the input when `in_valid` and `in_ready` are both high at a clock edge, and on the output when `out_valid` and `out_ready` are both high. When the output beat is held by a low `out_ready`, the whole pipeline freezes and `in_ready` drops in the same cycle. Bubbles inside the pipeline are not squeezed out. A producer may keep `in_valid` high while `in_ready` is low, and it must hold its operand, guard and tag stable until the beat is accepted.

Top module: `f2i_trunc_conv`

## Requirements
- R1: A normal operand whose unbiased exponent e lies in 0..30 yields its integer part with the sign applied, truncated toward zero (3.0 gives 3, 2.57 gives 2, -1.51 gives -1).
- R2: Flag bit 0 (inexact) is set exactly when a nonzero fraction is discarded. A normal operand with e below 0 yields 0 with inexact set.
- R3: A denormal operand (exponent field 0, fraction nonzero) is treated as zero: result 0, flag bit 2 (flushed) set, no other flag.
- R4: Positive and negative zero yield 0 with all flags clear.
- R5: Infinity, or a magnitude of 2^31 or more, yields 0x7FFFFFFF when positive and 0x80000000 when negative, with flag bit 1 (invalid) set.
- R6: The operand 0xCF000000 (exactly -2^31) yields 0x80000000 with all flags clear.
- R7: Any NaN, quiet or signalling, yields 0 with invalid set.
- R8: With `in_guard` low the beat emerges with `out_write` low and with result and flags all zero. With `in_guard` high, `out_write` is high.
- R9: A beat accepted in cycle n appears on the output in cycle n+3 if no output stall happens in between. Its tag travels with it, and beats leave in acceptance order.
- R10: While `out_valid` is high and `out_ready` is low, every output holds its value and `in_ready` is low. No beat is lost or duplicated.
- R11: At most one flag bit is set on any output beat.
- R12: During reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Pipeline can take a beat this cycle |
| in_operand | input | 32 | Single-precision operand |
| in_guard | input | 1 | Least significant bit of the guard operand |
| in_tag | input | TAG_W | Destination tag carried to the output |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| out_result | output | 32 | Signed integer result |
| out_flags | output | 3 | bit 2 flushed, bit 1 invalid, bit 0 inexact |
| out_write | output | 1 | Result and flags are to be committed |
| out_tag | output | TAG_W | Tag of the beat |

## Verification
The assertions assume a producer that obeys the stream rule: once it offers a beat it holds operand, guard and tag until the beat is accepted. They also assume that `out_ready` is driven to a known level in every cycle after reset. The bench changes inputs only one time unit after a rising edge and waits on `in_ready` before it drops a beat. The consumer side toggles `out_ready` freely, because the block must tolerate any pattern there. Operands come from a directed list of edge values and from random words whose exponent is biased toward the region near 2^0 to 2^31.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int INT_W  = 32;
  localparam int SHW    = 5;
  localparam int WIDE_W = INT_W - 1 + MAN_W;

  localparam logic [EXP_W-1:0] EXP_BIAS  = EXP_W'(127);
  localparam logic [EXP_W-1:0] EXP_LIMIT = EXP_W'(127 + INT_W - 1);
  localparam logic [EXP_W-1:0] EXP_ONES  = '1;

  localparam logic [INT_W-1:0] INT_POS_SAT = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] INT_NEG_SAT = {1'b1, {(INT_W-1){1'b0}}};

  // bit 2 flushed, bit 1 invalid, bit 0 inexact
  typedef struct packed {
    logic flushed;
    logic invalid;
    logic inexact;
  } f2i_flags_t;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_DENORM,
    CL_NAN,
    CL_INF,
    CL_TINY,
    CL_BIG,
    CL_MINEDGE,
    CL_NORMAL
  } f2i_class_t;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
(
  input  logic [FP_W-1:0]  operand,
  output logic             sign,
  output f2i_class_t       cls,
  output logic [SHW-1:0]   shamt,
  output logic [MAN_W:0]   mant
);
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] frac;
  logic [EXP_W-1:0] unb;

  assign sign = operand[FP_W-1];
  assign ex   = operand[FP_W-2:MAN_W];
  assign frac = operand[MAN_W-1:0];
  assign unb  = ex - EXP_BIAS;
  assign mant = {1'b1, frac};

  always_comb begin
    shamt = '0;
    if (ex == EXP_ONES) begin
      cls = (frac != '0) ? CL_NAN : CL_INF;
    end else if (ex == '0) begin
      cls = (frac != '0) ? CL_DENORM : CL_ZERO;
    end else if (ex < EXP_BIAS) begin
      cls = CL_TINY;
    end else if (ex >= EXP_LIMIT) begin
      cls = (sign && ex == EXP_LIMIT && frac == '0) ? CL_MINEDGE : CL_BIG;
    end else begin
      cls   = CL_NORMAL;
      shamt = unb[SHW-1:0];
    end
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
(
  input  logic [MAN_W:0]   mant,
  input  logic [SHW-1:0]   shamt,
  output logic [INT_W-2:0] mag,
  output logic             lost
);
  logic [WIDE_W-1:0] wide;

  assign wide = {{(WIDE_W-MAN_W-1){1'b0}}, mant} << shamt;
  assign mag  = wide[WIDE_W-1:MAN_W];
  assign lost = |wide[MAN_W-1:0];
endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
  import f2i_pkg::*;
(
  input  f2i_class_t       cls,
  input  logic             sign,
  input  logic [INT_W-2:0] mag,
  input  logic             lost,
  input  logic             guard_on,
  output logic [INT_W-1:0] result,
  output f2i_flags_t       flags
);
  logic [INT_W-1:0] raw;
  f2i_flags_t       rawf;
  logic [INT_W-1:0] sat;

  assign sat = sign ? INT_NEG_SAT : INT_POS_SAT;

  always_comb begin
    raw  = '0;
    rawf = '0;
    unique case (cls)
      CL_DENORM:  rawf.flushed = 1'b1;
      CL_NAN:     rawf.invalid = 1'b1;
      CL_INF,
      CL_BIG: begin
        raw          = sat;
        rawf.invalid = 1'b1;
      end
      CL_TINY:    rawf.inexact = 1'b1;
      CL_MINEDGE: raw = INT_NEG_SAT;
      CL_NORMAL: begin
        raw          = sign ? (~{1'b0, mag} + 1'b1) : {1'b0, mag};
        rawf.inexact = lost;
      end
      default: ;
    endcase
  end

  assign result = guard_on ? raw  : '0;
  assign flags  = guard_on ? rawf : '0;
endmodule

// File: rtl/f2i_trunc_conv.sv
module f2i_trunc_conv
  import f2i_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_operand,
  input  logic             in_guard,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [INT_W-1:0] out_result,
  output logic [2:0]       out_flags,
  output logic             out_write,
  output logic [TAG_W-1:0] out_tag
);
  logic adv;

  // stage 1: classification
  logic             c_sign;
  f2i_class_t       c_cls;
  logic [SHW-1:0]   c_shamt;
  logic [MAN_W:0]   c_mant;

  logic             s1_v, s1_gd, s1_sign;
  logic [TAG_W-1:0] s1_tag;
  f2i_class_t       s1_cls;
  logic [SHW-1:0]   s1_shamt;
  logic [MAN_W:0]   s1_mant;

  // stage 2: alignment
  logic [INT_W-2:0] a_mag;
  logic             a_lost;

  logic             s2_v, s2_gd, s2_sign, s2_lost;
  logic [TAG_W-1:0] s2_tag;
  f2i_class_t       s2_cls;
  logic [INT_W-2:0] s2_mag;

  // stage 3: sign, saturation, guard
  logic [INT_W-1:0] p_result;
  f2i_flags_t       p_flags;

  logic             s3_v, s3_wr;
  logic [TAG_W-1:0] s3_tag;
  logic [INT_W-1:0] s3_result;
  f2i_flags_t       s3_flags;

  assign adv      = !s3_v || out_ready;
  assign in_ready = adv;

  f2i_classify u_cls (
    .operand (in_operand),
    .sign    (c_sign),
    .cls     (c_cls),
    .shamt   (c_shamt),
    .mant    (c_mant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_gd    <= 1'b0;
      s1_sign  <= 1'b0;
      s1_tag   <= '0;
      s1_cls   <= CL_ZERO;
      s1_shamt <= '0;
      s1_mant  <= '0;
    end else if (adv) begin
      s1_v     <= in_valid;
      s1_gd    <= in_guard;
      s1_sign  <= c_sign;
      s1_tag   <= in_tag;
      s1_cls   <= c_cls;
      s1_shamt <= c_shamt;
      s1_mant  <= c_mant;
    end
  end

  f2i_align u_aln (
    .mant  (s1_mant),
    .shamt (s1_shamt),
    .mag   (a_mag),
    .lost  (a_lost)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s2_gd   <= 1'b0;
      s2_sign <= 1'b0;
      s2_lost <= 1'b0;
      s2_tag  <= '0;
      s2_cls  <= CL_ZERO;
      s2_mag  <= '0;
    end else if (adv) begin
      s2_v    <= s1_v;
      s2_gd   <= s1_gd;
      s2_sign <= s1_sign;
      s2_lost <= a_lost;
      s2_tag  <= s1_tag;
      s2_cls  <= s1_cls;
      s2_mag  <= a_mag;
    end
  end

  // stage-to-stage transfer keeps tag and order (R9)
  assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_v) |=> (s2_v && s2_tag == $past(s1_tag)));

  f2i_pack u_pk (
    .cls      (s2_cls),
    .sign     (s2_sign),
    .mag      (s2_mag),
    .lost     (s2_lost),
    .guard_on (s2_gd),
    .result   (p_result),
    .flags    (p_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_v      <= 1'b0;
      s3_wr     <= 1'b0;
      s3_tag    <= '0;
      s3_result <= '0;
      s3_flags  <= '0;
    end else if (adv) begin
      s3_v      <= s2_v;
      s3_wr     <= s2_gd;
      s3_tag    <= s2_tag;
      s3_result <= p_result;
      s3_flags  <= p_flags;
    end
  end

  assign out_valid  = s3_v;
  assign out_write  = s3_wr;
  assign out_tag    = s3_tag;
  assign out_result = s3_result;
  assign out_flags  = s3_flags;

  // a guarded NaN leaving stage 2 must surface as zero with invalid (R7)
  assert_nan_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s2_v && s2_gd && s2_cls == CL_NAN) |=>
      (out_flags == 3'b010 && out_result == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_flags) &&
       $stable(out_tag) && $stable(out_write)));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_write) |-> (out_flags == '0 && out_result == '0));

  assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_flags));

  assert_flush_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[2]) |-> out_result == '0);

  assert_invalid_values_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |->
      (out_result == '0 || out_result == INT_POS_SAT || out_result == INT_NEG_SAT));
endmodule

// File: tb/f2i_trunc_conv_test.sv
`timescale 1ns/1ps
module f2i_trunc_conv_test;
  localparam int TAG_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [31:0]      in_operand = '0;
  logic             in_guard = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [31:0]      out_result;
  logic [2:0]       out_flags;
  logic             out_write;
  logic [TAG_W-1:0] out_tag;

  int  tests = 0;
  int  fails = 0;
  int  edge_n = 0;
  int  stall_n = 0;
  bit  rdy_free = 1'b1;
  bit  done = 1'b0;

  typedef struct {
    logic [31:0]      op;
    logic             g;
    logic [TAG_W-1:0] tag;
    int               edge_in;
    int               stalls;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  f2i_trunc_conv #(.TAG_W(TAG_W)) uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_operand, .in_guard, .in_tag,
    .out_valid, .out_ready, .out_result, .out_flags, .out_write, .out_tag
  );

  function automatic void ref_conv(input logic [31:0] op, input logic g,
                                   output logic [31:0] r, output logic [2:0] f);
    int ex = int'(op[30:23]);
    int e = ex - 127;
    logic [22:0] fr = op[22:0];
    longint m;
    longint mag;
    r = '0;
    f = '0;
    if (!g) return;
    if (ex == 255) begin
      f = 3'b010;
      if (fr == 0) r = op[31] ? 32'h8000_0000 : 32'h7fff_ffff;
    end else if (ex == 0) begin
      if (fr != 0) f = 3'b100;
    end else if (e < 0) begin
      f = 3'b001;
    end else if (e >= 31) begin
      if (op[31] && e == 31 && fr == 0) r = 32'h8000_0000;
      else begin
        r = op[31] ? 32'h8000_0000 : 32'h7fff_ffff;
        f = 3'b010;
      end
    end else begin
      m = 64'sd8388608 + longint'(fr);
      if (e >= 23) mag = m <<< (e - 23);
      else begin
        mag = m >>> (23 - e);
        if ((m % (64'sd1 <<< (23 - e))) != 0) f = 3'b001;
      end
      r = op[31] ? 32'(-mag) : 32'(mag);
    end
  endfunction

  function automatic string req_of(input logic [31:0] op, input logic g);
    int ex = int'(op[30:23]);
    if (!g) return "R8";
    if (ex == 255) return (op[22:0] != 0) ? "R7" : "R5";
    if (ex == 0) return (op[22:0] != 0) ? "R3" : "R4";
    if (ex < 127) return "R2";
    if (ex >= 158) return (op == 32'hcf00_0000) ? "R6" : "R5";
    return "R1";
  endfunction

  always @(posedge clk) edge_n <= edge_n + 1;

  // reference model: push accepted beats, pop and compare delivered beats
  logic [31:0] prev_res;
  logic [2:0]  prev_flags;
  logic        prev_wr;
  logic [TAG_W-1:0] prev_tag;
  bit          prev_stall = 1'b0;

  always @(negedge clk) begin
    logic [31:0] er;
    logic [2:0]  ef;
    item_t it;
    if (!rst_n) begin
      tests++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R12 out_valid in reset: actual %b expected 0", out_valid);
      end
      prev_stall = 1'b0;
    end else begin
      tests++;
      if (in_ready !== !(out_valid && !out_ready)) begin
        fails++;
        $display("FAIL R10 in_ready: actual %b expected %b", in_ready, !(out_valid && !out_ready));
      end
      if (prev_stall) begin
        tests++;
        if (!out_valid || out_result !== prev_res || out_flags !== prev_flags ||
            out_write !== prev_wr || out_tag !== prev_tag) begin
          fails++;
          $display("FAIL R10 hold: actual %h/%b expected %h/%b", out_result, out_flags, prev_res, prev_flags);
        end
      end
      if (out_valid && out_ready) begin
        tests++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R10 extra beat: actual tag %0d expected none", out_tag);
        end else begin
          it = q.pop_front();
          ref_conv(it.op, it.g, er, ef);
          if (out_result !== er || out_flags !== ef || out_write !== it.g || out_tag !== it.tag) begin
            fails++;
            $display("FAIL %s op %h: actual %h flags %b wr %b tag %0d expected %h flags %b wr %b tag %0d",
                     req_of(it.op, it.g), it.op, out_result, out_flags, out_write, out_tag,
                     er, ef, it.g, it.tag);
          end
          tests++;
          if ((it.stalls == stall_n && edge_n + 1 - it.edge_in != 3) ||
              (it.stalls != stall_n && edge_n + 1 - it.edge_in <= 3)) begin
            fails++;
            $display("FAIL R9 latency: actual %0d expected %0d", edge_n + 1 - it.edge_in, 3);
          end
        end
      end
      if (in_valid && in_ready) begin
        it.op = in_operand; it.g = in_guard; it.tag = in_tag;
        it.edge_in = edge_n + 1; it.stalls = stall_n;
        q.push_back(it);
      end
      prev_stall = out_valid && !out_ready;
      if (prev_stall) stall_n++;
      prev_res = out_result; prev_flags = out_flags; prev_wr = out_write; prev_tag = out_tag;
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = rdy_free ? 1'b1 : ($urandom_range(0, 2) != 0);
  end

  task automatic send(input logic [31:0] op, input logic g, input int gap);
    in_valid = 1'b1; in_operand = op; in_guard = g;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_tag = in_tag + 1'b1;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  logic [31:0] dlist [24] = '{
    32'h4040_0000, 32'h4024_7ae1, 32'hbfc1_47ae, 32'hff4f_ffff,
    32'h7f80_0000, 32'hff80_0000, 32'h0040_0000, 32'h8000_0001,
    32'hffff_ffff, 32'hffbf_ffff, 32'h7fc0_0000, 32'h0000_0000,
    32'h8000_0000, 32'hcf00_0000, 32'hcf00_0001, 32'h4f00_0000,
    32'h3f00_0000, 32'hbf7f_ffff, 32'h4eff_ffff, 32'hceff_ffff,
    32'h3f80_0000, 32'h4b80_0001, 32'h4b00_0001, 32'hcb7f_ffff
  };

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // directed, back-to-back, consumer always ready (R1-R7, R9)
    foreach (dlist[i]) send(dlist[i], 1'b1, 0);
    // guard false on the same values (R8)
    for (int i = 0; i < 6; i++) send(dlist[i*3], 1'b0, i % 2);
    // random operands under random back-pressure (R10, R11)
    rdy_free = 1'b0;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] op = $urandom();
      if (i % 2 == 0) op[30:23] = 8'($urandom_range(110, 165));
      send(op, ($urandom_range(0, 3) != 0), $urandom_range(0, 2) == 0 ? 1 : 0);
    end
    rdy_free = 1'b1;
    for (int i = 0; i < 40; i++) send(dlist[i % 24] ^ 32'($urandom_range(0, 3)), 1'b1, 0);
    repeat (10) @(posedge clk);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10 beats left: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule